// File: doc/BRIEF.md
# Radio Interrupt Status Controller

This block gathers the event and condition signals of a packet radio's receive and transmit paths into two 8-bit status registers. The first status register holds FIFO and packet events. The second holds link and chip conditions. Each status register has an 8-bit enable register beside it. A single active-low interrupt line is low whenever any status bit is set while its enable bit is also set.

Most inputs are one-cycle pulses. Two kinds of bit share the registers:
- Sticky bits capture a pulse and hold it until the host reads their register.
- Tracking bits follow the receive sequence. They set on one event and clear on another, and a read does not change them.

An event that arrives while its enable bit is 0 is still recorded. It drives the interrupt line as soon as software sets the matching enable bit.

The host reaches the four registers through a simple port with an address, read and write strobes, write data and combinational read data. A read strobe on a status address returns that register's contents. The sticky bits of that register are cleared at the same clock edge.

Top module: `radio_irq_status`

## Requirements
- R1: After reset, both enable registers and the packet status register read 0x00, the link status register reads 0x01, and irq_n is high.
- R2: Address 0 is the packet status register. Bit k of pkt_events sets bit k, and the bit stays set until a read of address 0. That read returns the value held before it clears the register to zero.
- R3: An event pulse that arrives in the same cycle as a read of its status register is not lost. Its bit is set after that read.
- R4: Link status (address 1) bit 7, sync seen, sets on sync_found and clears on packet_end. If both arrive together, sync_found wins. A read does not clear this bit.
- R5: Link status bit 6, preamble good, sets on preamble_found. It clears on sync_found or on sync_timeout, and preamble_found wins if both arrive together. A sync_timeout does not set bit 7.
- R6: Link status bit 4 is rssi_high sampled at the previous clock edge.
- R7: Link status bits 5 (preamble_bad), 3 (wake_tick) and 2 (batt_low) are sticky. Each is set by its pulse and cleared by a read of address 1.
- R8: Link status bit 1, ready, sets on xtal_settled and clears on enter_idle. If both arrive together, xtal_settled wins. A read does not clear this bit.
- R9: Link status bit 0, power-on, is set only by reset and is cleared by the first read of address 1.
- R10: irq_n is low exactly when (packet status AND packet enable) OR (link status AND link enable) is nonzero. An event recorded while masked pulls irq_n low in the cycle after its enable bit is written.
- R11: Addresses 2 and 3 are the packet and link enable registers. They are written by reg_wr and read back unchanged. A write to address 0 or 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, clears sticky bits of the addressed status register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the addressed register |
| pkt_events | input | REG_W | Packet/FIFO event pulses: 7 FIFO error, 6 TX almost full, 5 TX almost empty, 4 RX almost full, 3 external, 2 packet sent, 1 packet valid, 0 CRC error |
| sync_found | input | 1 | Sync word detected pulse |
| preamble_found | input | 1 | Preamble detected pulse |
| preamble_bad | input | 1 | Preamble invalid pulse |
| sync_timeout | input | 1 | Wait-for-sync timeout pulse |
| packet_end | input | 1 | Reception of current packet finished |
| rssi_high | input | 1 | Live signal-strength-above-threshold level |
| wake_tick | input | 1 | Wake timer pulse |
| batt_low | input | 1 | Low battery pulse |
| xtal_settled | input | 1 | Crystal settling time elapsed pulse |
| enter_idle | input | 1 | Return to idle mode pulse |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: REG_W of 8 and ADDR_W of 2. With these values all four addresses are reachable, and so is every bit position of both status and enable registers. The random phase can therefore hit collisions between an event and a read, or between an enable write and a pending bit, on any bit. Directed sequences walk the receive flow in order: preamble, then sync or timeout, then end of packet. They also cover the masked low-battery case.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_STAT_PKT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT_LINK = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_EN_PKT    = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_EN_LINK   = 2'd3;

    // link status bit positions
    localparam int LB_SYNC    = 7;
    localparam int LB_PRE_OK  = 6;
    localparam int LB_PRE_BAD = 5;
    localparam int LB_RSSI    = 4;
    localparam int LB_WAKE    = 3;
    localparam int LB_BATT    = 2;
    localparam int LB_READY   = 1;
    localparam int LB_POR     = 0;

    localparam int STICKY_LINK_W = 4;

    typedef struct packed {
        logic sync;
        logic pre_ok;
        logic rssi;
        logic ready;
    } link_t;
endpackage

// File: rtl/risc_sticky_bank.sv
module risc_sticky_bank #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] bits_o
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = clr_i ? '0 : bits_q;
        bits_d = bits_d | set_i;   // new event survives a same-cycle clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= RST_VAL;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/risc_link_tracker.sv
module risc_link_tracker
    import radio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_found,
    input  logic  preamble_found,
    input  logic  sync_timeout,
    input  logic  packet_end,
    input  logic  rssi_high,
    input  logic  xtal_settled,
    input  logic  enter_idle,
    output link_t link_o
);
    link_t link_d, link_q;

    always_comb begin
        link_d = link_q;
        if (sync_found)                    link_d.sync = 1'b1;
        else if (packet_end)               link_d.sync = 1'b0;

        if (preamble_found)                link_d.pre_ok = 1'b1;
        else if (sync_found || sync_timeout) link_d.pre_ok = 1'b0;

        link_d.rssi = rssi_high;

        if (xtal_settled)                  link_d.ready = 1'b1;
        else if (enter_idle)               link_d.ready = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_q <= '0;
        else        link_q <= link_d;
    end

    assign link_o = link_q;
endmodule

// File: rtl/risc_irq_merge.sv
module risc_irq_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] stat_a,
    input  logic [W-1:0] en_a,
    input  logic [W-1:0] stat_b,
    input  logic [W-1:0] en_b,
    output logic         irq_n
);
    logic [W-1:0] hit;
    assign hit   = (stat_a & en_a) | (stat_b & en_b);
    assign irq_n = ~(|hit);
endmodule

// File: rtl/radio_irq_status.sv
module radio_irq_status
    import radio_irq_pkg::*;
#(
    parameter int P_REG_W  = REG_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_ADDR_W-1:0] reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [P_REG_W-1:0]  reg_wdata,
    output logic [P_REG_W-1:0]  reg_rdata,
    input  logic [P_REG_W-1:0]  pkt_events,
    input  logic                sync_found,
    input  logic                preamble_found,
    input  logic                preamble_bad,
    input  logic                sync_timeout,
    input  logic                packet_end,
    input  logic                rssi_high,
    input  logic                wake_tick,
    input  logic                batt_low,
    input  logic                xtal_settled,
    input  logic                enter_idle,
    output logic                irq_n
);
    typedef struct packed {
        logic [P_REG_W-1:0] en_pkt;
        logic [P_REG_W-1:0] en_link;
    } en_t;

    en_t en_d, en_q;

    logic rd_pkt, rd_link;
    assign rd_pkt  = reg_rd && (reg_addr == P_ADDR_W'(ADR_STAT_PKT));
    assign rd_link = reg_rd && (reg_addr == P_ADDR_W'(ADR_STAT_LINK));

    // enable registers (R11)
    always_comb begin
        en_d = en_q;
        if (reg_wr && reg_addr == P_ADDR_W'(ADR_EN_PKT))  en_d.en_pkt  = reg_wdata;
        if (reg_wr && reg_addr == P_ADDR_W'(ADR_EN_LINK)) en_d.en_link = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // packet status: all sticky (R2, R3)
    logic [P_REG_W-1:0] stat_pkt;
    risc_sticky_bank #(.W(P_REG_W), .RST_VAL('0)) u_pkt_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pkt_events),
        .clr_i  (rd_pkt),
        .bits_o (stat_pkt)
    );

    // link status sticky part: {pre_bad, wake, batt, por} (R7, R9)
    logic [STICKY_LINK_W-1:0] link_sticky;
    risc_sticky_bank #(.W(STICKY_LINK_W), .RST_VAL(4'b0001)) u_link_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({preamble_bad, wake_tick, batt_low, 1'b0}),
        .clr_i  (rd_link),
        .bits_o (link_sticky)
    );

    // link status tracking part (R4, R5, R6, R8)
    link_t link_lvl;
    risc_link_tracker u_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_found     (sync_found),
        .preamble_found (preamble_found),
        .sync_timeout   (sync_timeout),
        .packet_end     (packet_end),
        .rssi_high      (rssi_high),
        .xtal_settled   (xtal_settled),
        .enter_idle     (enter_idle),
        .link_o         (link_lvl)
    );

    logic [P_REG_W-1:0] stat_link;
    always_comb begin
        stat_link             = '0;
        stat_link[LB_SYNC]    = link_lvl.sync;
        stat_link[LB_PRE_OK]  = link_lvl.pre_ok;
        stat_link[LB_PRE_BAD] = link_sticky[3];
        stat_link[LB_RSSI]    = link_lvl.rssi;
        stat_link[LB_WAKE]    = link_sticky[2];
        stat_link[LB_BATT]    = link_sticky[1];
        stat_link[LB_READY]   = link_lvl.ready;
        stat_link[LB_POR]     = link_sticky[0];
    end

    // read mux
    always_comb begin
        unique case (reg_addr)
            P_ADDR_W'(ADR_STAT_PKT):  reg_rdata = stat_pkt;
            P_ADDR_W'(ADR_STAT_LINK): reg_rdata = stat_link;
            P_ADDR_W'(ADR_EN_PKT):    reg_rdata = en_q.en_pkt;
            default:                  reg_rdata = en_q.en_link;
        endcase
    end

    // interrupt (R10)
    risc_irq_merge #(.W(P_REG_W)) u_irq (
        .stat_a (stat_pkt),
        .en_a   (en_q.en_pkt),
        .stat_b (stat_link),
        .en_b   (en_q.en_link),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/radio_irq_status_chk.sv
module radio_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       irq_n,
    input logic [7:0] pkt_events,
    input logic       sync_timeout,
    input logic       preamble_found,
    input logic       rssi_high,
    input logic [7:0] stat_pkt,
    input logic [7:0] stat_link
);
    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == 2'd0) |=> ((stat_pkt & $past(stat_pkt)) == $past(stat_pkt))); // R2

    AST_EVENT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && pkt_events != 8'h00) |=> ((stat_pkt & $past(pkt_events)) == $past(pkt_events))); // R3

    AST_TIMEOUT_DROPS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_timeout && !preamble_found) |=> !stat_link[6]); // R5

    AST_RSSI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rssi_high |=> stat_link[4]); // R6

    AST_RSSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rssi_high |=> !stat_link[4]); // R6

    AST_POR_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1) |=> !stat_link[0]); // R9

    AST_ENABLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == 2'd2 && (reg_wdata & stat_pkt) != 8'h00) |=> !irq_n); // R10
endmodule

bind radio_irq_status radio_irq_status_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_rd         (reg_rd),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .irq_n          (irq_n),
    .pkt_events     (pkt_events),
    .sync_timeout   (sync_timeout),
    .preamble_found (preamble_found),
    .rssi_high      (rssi_high),
    .stat_pkt       (stat_pkt),
    .stat_link      (stat_link)
);

// File: tb/radio_irq_status_bench.sv
module radio_irq_status_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] pkt_events = '0;
    logic sync_found = 0, preamble_found = 0, preamble_bad = 0, sync_timeout = 0;
    logic packet_end = 0, rssi_high = 0, wake_tick = 0, batt_low = 0;
    logic xtal_settled = 0, enter_idle = 0;
    logic irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_irq_status u_radio_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_events(pkt_events),
        .sync_found(sync_found), .preamble_found(preamble_found), .preamble_bad(preamble_bad),
        .sync_timeout(sync_timeout), .packet_end(packet_end), .rssi_high(rssi_high),
        .wake_tick(wake_tick), .batt_low(batt_low), .xtal_settled(xtal_settled),
        .enter_idle(enter_idle), .irq_n(irq_n)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_pkt = 8'h00, m_en_pkt = 8'h00, m_en_link = 8'h00;
    logic m_sync = 0, m_pre = 0, m_bad = 0, m_rssi = 0, m_wake = 0, m_batt = 0, m_ready = 0, m_por = 1;

    function automatic logic [7:0] m_link();
        return {m_sync, m_pre, m_bad, m_rssi, m_wake, m_batt, m_ready, m_por};
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_pkt;
            2'd1: return m_link();
            2'd2: return m_en_pkt;
            default: return m_en_link;
        endcase
    endfunction

    function automatic logic m_irq();
        return ((m_pkt & m_en_pkt) | (m_link() & m_en_link)) == 8'h00;
    endfunction

    task automatic model_step();
        logic rd0, rd1;
        rd0 = reg_rd && reg_addr == 2'd0;
        rd1 = reg_rd && reg_addr == 2'd1;
        m_pkt  = (rd0 ? 8'h00 : m_pkt) | pkt_events;
        m_bad  = (rd1 ? 1'b0 : m_bad)  | preamble_bad;
        m_wake = (rd1 ? 1'b0 : m_wake) | wake_tick;
        m_batt = (rd1 ? 1'b0 : m_batt) | batt_low;
        if (rd1) m_por = 1'b0;
        if (sync_found) m_sync = 1'b1; else if (packet_end) m_sync = 1'b0;
        if (preamble_found) m_pre = 1'b1; else if (sync_found || sync_timeout) m_pre = 1'b0;
        m_rssi = rssi_high;
        if (xtal_settled) m_ready = 1'b1; else if (enter_idle) m_ready = 1'b0;
        if (reg_wr && reg_addr == 2'd2) m_en_pkt  = reg_wdata;
        if (reg_wr && reg_addr == 2'd3) m_en_link = reg_wdata;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R2";
            2'd1: return "R7";
            default: return "R11";
        endcase
    endfunction

    // one cycle: inputs already set just after a falling edge
    task automatic tick();
        #1;
        if (reg_rd) check(rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R10", {7'b0, irq_n}, {7'b0, m_irq()});
        reg_rd = 0; reg_wr = 0; pkt_events = '0;
        sync_found = 0; preamble_found = 0; preamble_bad = 0; sync_timeout = 0;
        packet_end = 0; wake_tick = 0; batt_low = 0; xtal_settled = 0; enter_idle = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1;
        #1 v = reg_rdata;
        tick();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wr = 1; reg_wdata = d;
        tick();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x01 expected 0x00");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1", {7'b0, irq_n}, 8'h01);
        rd_reg(2'd0, v); check("R1", v, 8'h00);
        rd_reg(2'd2, v); check("R1", v, 8'h00);
        rd_reg(2'd3, v); check("R1", v, 8'h00);
        rd_reg(2'd1, v); check("R1", v, 8'h01);
        // R9 power-on cleared by first read
        rd_reg(2'd1, v); check("R9", v, 8'h00);

        // R10 masked low battery stays pending until enabled
        batt_low = 1; tick();
        check("R10", {7'b0, irq_n}, 8'h01);
        wr_reg(2'd3, 8'h04);
        check("R10", {7'b0, irq_n}, 8'h00);
        rd_reg(2'd1, v); check("R7", v, 8'h04);
        check("R10", {7'b0, irq_n}, 8'h01);
        wr_reg(2'd3, 8'h00);

        // R5 timeout clears preamble good, does not set sync
        preamble_found = 1; tick();
        rd_reg(2'd1, v); check("R5", v, 8'h40);
        sync_timeout = 1; tick();
        rd_reg(2'd1, v); check("R5", v, 8'h00);

        // R4 sync sequence
        preamble_found = 1; tick();
        sync_found = 1; tick();
        rd_reg(2'd1, v); check("R4", v, 8'h80);
        rd_reg(2'd1, v); check("R4", v, 8'h80);
        packet_end = 1; tick();
        rd_reg(2'd1, v); check("R4", v, 8'h00);

        // R3 event during read
        reg_addr = 2'd0; reg_rd = 1; pkt_events = 8'h21; tick();
        rd_reg(2'd0, v); check("R3", v, 8'h21);
        rd_reg(2'd0, v); check("R2", v, 8'h00);
        pkt_events = 8'h80; tick();
        rd_reg(2'd0, v); check("R2", v, 8'h80);

        // R6 live RSSI
        rssi_high = 1; tick();
        rd_reg(2'd1, v); check("R6", v, 8'h10);
        rssi_high = 0; tick();
        rd_reg(2'd1, v); check("R6", v, 8'h00);

        // R8 ready
        xtal_settled = 1; tick();
        rd_reg(2'd1, v); check("R8", v, 8'h02);
        enter_idle = 1; tick();
        rd_reg(2'd1, v); check("R8", v, 8'h00);

        // R7 sticky link events
        wake_tick = 1; preamble_bad = 1; tick();
        rd_reg(2'd1, v); check("R7", v, 8'h28);
        rd_reg(2'd1, v); check("R7", v, 8'h00);

        // R11 enables, ignored writes
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, v); check("R11", v, 8'h00);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, v); check("R11", v, 8'h00);
        wr_reg(2'd2, 8'hA5);
        rd_reg(2'd2, v); check("R11", v, 8'hA5);

        // random phase
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) begin reg_rd = 1; reg_addr = 2'($urandom_range(0, 3)); end
            if ($urandom_range(0, 5) == 0) begin
                reg_wr = 1; reg_addr = 2'($urandom_range(0, 3)); reg_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 3) == 0) pkt_events = 8'($urandom) & 8'($urandom);
            sync_found     = ($urandom_range(0, 9) == 0);
            preamble_found = ($urandom_range(0, 7) == 0);
            preamble_bad   = ($urandom_range(0, 9) == 0);
            sync_timeout   = ($urandom_range(0, 9) == 0);
            packet_end     = ($urandom_range(0, 7) == 0);
            wake_tick      = ($urandom_range(0, 9) == 0);
            batt_low       = ($urandom_range(0, 15) == 0);
            xtal_settled   = ($urandom_range(0, 9) == 0);
            enter_idle     = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 7) == 0) rssi_high = ~rssi_high;
            tick();
        end

        finish_up();
    end
endmodule